// File: doc/BRIEF.md
# Branch Resolution Unit

This unit resolves one jump-class instruction per accepted request. It receives the 5-bit operation code, the two register operand values, the register index named as link destination, the trailing constant that followed the instruction word in memory, and the address just past that constant. From these it decides whether control is redirected, computes the next program counter, and says whether a return address is written to a register, and what that value is.

Three kinds of jump are handled: an indirect jump through a register that also links, a PC-relative jump that links, and six PC-relative conditional branches that compare the two register operands as signed numbers. A code that is not a jump is flagged illegal and never redirects. The decision is combinational and is captured in one output register stage. A result appears one cycle after `in_valid` and is marked by a one-cycle `out_valid`.

Top module: `branch_resolve`

## Requirements
- R1: Opcode codes, with the low two bits always 01: 00001 register jump-and-link, 00101 relative jump-and-link, 01001 equal, 01101 not equal, 10001 less than, 10101 greater than, 11001 less or equal, 11101 greater or equal.
- R2: The register jump-and-link is always taken, with `next_pc` equal to `opnd_b` and a link value of `fall_pc`.
- R3: The relative jump-and-link is always taken, with `next_pc` equal to `fall_pc + offset` modulo 2^XLEN and a link value of `fall_pc`.
- R4: A conditional branch compares `opnd_a` with `opnd_b` as signed two's-complement values. When the condition holds it is taken, with `next_pc` equal to `fall_pc + offset`.
- R5: A conditional branch whose condition fails is not taken, and `next_pc` equals `fall_pc`. It never requests a link write.
- R6: A link write targets `link_idx`. When `link_idx` is 0 the write is suppressed (`link_we` low) while `taken` and `next_pc` are unchanged.
- R7: An opcode whose low two bits are not 01 raises `illegal`, with `taken` and `link_we` low and `next_pc` equal to `fall_pc`.
- R8: `out_valid` rises exactly one cycle after each `in_valid` cycle, for one cycle. The result fields belong to that request and hold while no new request arrives.
- R9: Synchronous active-low reset clears `out_valid`, `taken`, `link_we` and `illegal`, and zeroes `next_pc` and `link_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 5 | Jump operation code |
| opnd_a | input | XLEN | First register operand |
| opnd_b | input | XLEN | Second register operand, also the indirect target |
| link_idx | input | RIDX | Link destination register index |
| offset | input | XLEN | Trailing constant, already sign-extended |
| fall_pc | input | XLEN | Address just past the trailing constant |
| out_valid | output | 1 | Result present |
| taken | output | 1 | Control is redirected |
| next_pc | output | XLEN | Next program counter |
| link_we | output | 1 | Register write of the return address |
| link_dst | output | RIDX | Register index for the link write |
| link_val | output | XLEN | Return address value |
| illegal | output | 1 | Opcode is not a jump |

## Verification
A wrong comparison, opcode decode or adder fault shows directly in `taken` or `next_pc` in the cycle after the request, because there is no state apart from the output register. A stuck or doubled valid register shows as `out_valid` missing or lasting two cycles. A bad link-suppression term shows as `link_we` high with a zero destination in that same result cycle.

// File: rtl/branch_resolve_pkg.sv
// Package: shared opcode codes and result record for the branch resolution unit.
// Assumes the jump class is marked by the two low opcode bits being 01.
package branch_resolve_pkg;

    localparam int OP_W = 5;

    typedef enum logic [2:0] {
        SEL_JRL = 3'd0,
        SEL_JAL = 3'd1,
        SEL_EQ  = 3'd2,
        SEL_NE  = 3'd3,
        SEL_LT  = 3'd4,
        SEL_GT  = 3'd5,
        SEL_LE  = 3'd6,
        SEL_GE  = 3'd7
    } jsel_e;

    localparam logic [1:0] JCLASS = 2'b01;

    typedef struct packed {
        logic  legal;
        jsel_e sel;
        logic  is_cond;
        logic  links;
        logic  indirect;
    } jdec_t;

endpackage

// File: rtl/br_decode.sv
// Module: br_decode
// Turns a 5-bit opcode into a jump selector and class flags.
// Assumes the upper three bits select among eight jump kinds when the low bits are 01.
module br_decode
    import branch_resolve_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output jdec_t           dec
);

    // Classify the opcode into selector and flags.
    always_comb begin
        dec.legal    = (op[1:0] == JCLASS);
        dec.sel      = jsel_e'(op[4:2]);
        dec.is_cond  = dec.legal && (op[4:2] >= 3'd2);
        dec.links    = dec.legal && (op[4:2] <= 3'd1);
        dec.indirect = dec.legal && (op[4:2] == 3'd0);
    end

endmodule

// File: rtl/br_compare.sv
// Module: br_compare
// Evaluates the six signed relations between two operands and picks one by selector.
// Assumes two's-complement operands of XLEN bits; non-condition selectors yield 0.
module br_compare
    import branch_resolve_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  jsel_e           sel,
    output logic            hold
);

    logic eq, lt;

    // Base relations computed once; others derived.
    always_comb begin
        eq = (a == b);
        lt = ($signed(a) < $signed(b));
    end

    // Pick the relation named by the selector.
    always_comb begin
        unique case (sel)
            SEL_EQ:  hold = eq;
            SEL_NE:  hold = !eq;
            SEL_LT:  hold = lt;
            SEL_GT:  hold = !lt && !eq;
            SEL_LE:  hold = lt || eq;
            SEL_GE:  hold = !lt;
            default: hold = 1'b0;
        endcase
    end

endmodule

// File: rtl/br_target.sv
// Module: br_target
// Forms the redirect target: register value for the indirect form, else fall_pc + offset.
// Assumes addition wraps modulo 2^XLEN.
module br_target #(
    parameter int XLEN = 64
) (
    input  logic            indirect,
    input  logic [XLEN-1:0] reg_tgt,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] target
);

    // Select between indirect and relative target.
    always_comb begin
        target = indirect ? reg_tgt : (base + offset);
    end

endmodule

// File: rtl/branch_resolve.sv
// Module: branch_resolve
// Resolves one jump-class request: decision, next PC and link write, captured one cycle later.
// Assumes offset is already sign-extended and fall_pc points past the trailing constant.
module branch_resolve
    import branch_resolve_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 16,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [4:0]      op,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [RIDX-1:0] link_idx,
    input  logic [XLEN-1:0] offset,
    input  logic [XLEN-1:0] fall_pc,
    output logic            out_valid,
    output logic            taken,
    output logic [XLEN-1:0] next_pc,
    output logic            link_we,
    output logic [RIDX-1:0] link_dst,
    output logic [XLEN-1:0] link_val,
    output logic            illegal
);

    jdec_t           dec;
    logic            cond_ok;
    logic [XLEN-1:0] tgt;
    logic            c_taken;
    logic [XLEN-1:0] c_next;
    logic            c_lwe;

    br_decode u_dec (
        .op  (op),
        .dec (dec)
    );

    br_compare #(.XLEN(XLEN)) u_cmp (
        .a    (opnd_a),
        .b    (opnd_b),
        .sel  (dec.sel),
        .hold (cond_ok)
    );

    br_target #(.XLEN(XLEN)) u_tgt (
        .indirect (dec.indirect),
        .reg_tgt  (opnd_b),
        .base     (fall_pc),
        .offset   (offset),
        .target   (tgt)
    );

    // Combine decode and compare into the redirect decision and link request.
    always_comb begin
        c_taken = dec.legal && (dec.links || cond_ok);
        c_next  = c_taken ? tgt : fall_pc;
        c_lwe   = dec.links && (link_idx != '0);
    end

    // Output register stage with one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            next_pc   <= '0;
            link_we   <= 1'b0;
            link_dst  <= '0;
            link_val  <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                taken    <= c_taken;
                next_pc  <= c_next;
                link_we  <= c_lwe;
                link_dst <= link_idx;
                link_val <= fall_pc;
                illegal  <= !dec.legal;
            end
        end
    end

endmodule

// File: rtl/branch_resolve_chk.sv
// Module: branch_resolve_chk
// Port-level temporal checks for branch_resolve, attached by bind.
module branch_resolve_chk #(
    parameter int XLEN = 64,
    parameter int RIDX = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [4:0]      op,
    input logic [XLEN-1:0] fall_pc,
    input logic            out_valid,
    input logic            taken,
    input logic [XLEN-1:0] next_pc,
    input logic            link_we,
    input logic [RIDX-1:0] link_dst,
    input logic            illegal
);

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6
    no_zero_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(link_we && link_dst == '0));

    // R7
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!taken && !link_we));

    // R7
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[1:0] != 2'b01) |=> illegal);

    // R5
    not_taken_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[1:0] == 2'b01 && op[4:3] != 2'b00) |=>
            (taken || (next_pc == $past(fall_pc) && !link_we)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> $stable(next_pc));

endmodule

bind branch_resolve branch_resolve_chk #(.XLEN(XLEN), .RIDX(RIDX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .fall_pc   (fall_pc),
    .out_valid (out_valid),
    .taken     (taken),
    .next_pc   (next_pc),
    .link_we   (link_we),
    .link_dst  (link_dst),
    .illegal   (illegal)
);

// File: tb/test_branch_resolve.sv
module test_branch_resolve;

    localparam int  CLK_PERIOD = 10;
    localparam int  XLEN = 64;
    localparam int  RIDX = 4;
    localparam int  NV = 20;

    logic            clk = 0;
    logic            rst_n = 0;
    logic            in_valid = 0;
    logic [4:0]      op = 0;
    logic [XLEN-1:0] opnd_a = 0, opnd_b = 0, offset = 0, fall_pc = 0;
    logic [RIDX-1:0] link_idx = 0;
    logic            out_valid, taken, link_we, illegal;
    logic [XLEN-1:0] next_pc, link_val;
    logic [RIDX-1:0] link_dst;

    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_resolve #(.XLEN(XLEN), .NREG(16)) i_branch_resolve (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .link_idx(link_idx),
        .offset(offset), .fall_pc(fall_pc), .out_valid(out_valid),
        .taken(taken), .next_pc(next_pc), .link_we(link_we),
        .link_dst(link_dst), .link_val(link_val), .illegal(illegal)
    );

    // Vector: op, a, b, link_idx, offset, fall_pc, exp taken, exp next, exp lwe, exp illegal
    typedef struct packed {
        logic [4:0]      op;
        logic [63:0]     a;
        logic [63:0]     b;
        logic [3:0]      li;
        logic [63:0]     off;
        logic [63:0]     pc;
        logic            t;
        logic [63:0]     nx;
        logic            lw;
        logic            il;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        // R2 register jump-and-link
        '{5'b00001, 64'd5, 64'h4000, 4'd3, 64'd0, 64'h104, 1'b1, 64'h4000, 1'b1, 1'b0},
        // R3 relative jump-and-link, forward and wrap
        '{5'b00101, 64'd0, 64'd0, 4'd1, 64'h20, 64'h104, 1'b1, 64'h124, 1'b1, 1'b0},
        '{5'b00101, 64'd0, 64'd0, 4'd1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8, 1'b1, 64'hFFFF_FFFF_FFFF_FFF8, 1'b1, 1'b0},
        // R4/R5 equal
        '{5'b01001, 64'd7, 64'd7, 4'd2, 64'h10, 64'h200, 1'b1, 64'h210, 1'b0, 1'b0},
        '{5'b01001, 64'd7, 64'd8, 4'd2, 64'h10, 64'h200, 1'b0, 64'h200, 1'b0, 1'b0},
        // not equal
        '{5'b01101, 64'd7, 64'd8, 4'd2, 64'hFFFF_FFFF_FFFF_FFFC, 64'h200, 1'b1, 64'h1FC, 1'b0, 1'b0},
        '{5'b01101, 64'd9, 64'd9, 4'd2, 64'h4, 64'h200, 1'b0, 64'h200, 1'b0, 1'b0},
        // less than, signed: -1 < 1
        '{5'b10001, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 4'd0, 64'h8, 64'h300, 1'b1, 64'h308, 1'b0, 1'b0},
        '{5'b10001, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 64'h8, 64'h300, 1'b0, 64'h300, 1'b0, 1'b0},
        '{5'b10001, 64'd4, 64'd4, 4'd0, 64'h8, 64'h300, 1'b0, 64'h300, 1'b0, 1'b0},
        // greater than
        '{5'b10101, 64'd1, 64'h8000_0000_0000_0000, 4'd0, 64'h8, 64'h300, 1'b1, 64'h308, 1'b0, 1'b0},
        '{5'b10101, 64'd4, 64'd4, 4'd0, 64'h8, 64'h300, 1'b0, 64'h300, 1'b0, 1'b0},
        // less or equal
        '{5'b11001, 64'd4, 64'd4, 4'd0, 64'h8, 64'h300, 1'b1, 64'h308, 1'b0, 1'b0},
        '{5'b11001, 64'd5, 64'd4, 4'd0, 64'h8, 64'h300, 1'b0, 64'h300, 1'b0, 1'b0},
        // greater or equal
        '{5'b11101, 64'd4, 64'd4, 4'd0, 64'h8, 64'h300, 1'b1, 64'h308, 1'b0, 1'b0},
        '{5'b11101, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 4'd0, 64'h8, 64'h300, 1'b0, 64'h300, 1'b0, 1'b0},
        // R6 link to register 0 suppressed
        '{5'b00001, 64'd0, 64'h5000, 4'd0, 64'd0, 64'h104, 1'b1, 64'h5000, 1'b0, 1'b0},
        '{5'b00101, 64'd0, 64'd0, 4'd0, 64'h40, 64'h104, 1'b1, 64'h144, 1'b0, 1'b0},
        // R7 non-jump codes
        '{5'b00010, 64'd1, 64'd1, 4'd5, 64'h40, 64'h400, 1'b0, 64'h400, 1'b0, 1'b1},
        '{5'b01011, 64'd1, 64'd1, 4'd5, 64'h40, 64'h400, 1'b0, 64'h400, 1'b0, 1'b1}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op = v.op; opnd_a = v.a; opnd_b = v.b; link_idx = v.li;
        offset = v.off; fall_pc = v.pc; in_valid = 1;
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD*5000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check(out_valid == 0 && taken == 0 && link_we == 0 && illegal == 0,
              "R9", "flags", {out_valid, taken, link_we, illegal}, 0);
        check(next_pc == 0 && link_val == 0, "R9", "values", next_pc | link_val, 0);
        rst_n = 1;
        @(posedge clk); #1;

        // R1 R2 R3 R4 R5 R6 R7 vector walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check(out_valid == 1, "R8", "out_valid", out_valid, 1);
            check(taken == VECS[i].t, "R1", $sformatf("taken v%0d", i), taken, VECS[i].t);
            check(next_pc == VECS[i].nx, "R4", $sformatf("next_pc v%0d", i), next_pc, VECS[i].nx);
            check(link_we == VECS[i].lw, "R6", $sformatf("link_we v%0d", i), link_we, VECS[i].lw);
            check(illegal == VECS[i].il, "R7", $sformatf("illegal v%0d", i), illegal, VECS[i].il);
            if (VECS[i].lw) begin
                check(link_val == VECS[i].pc, "R3", "link_val", link_val, VECS[i].pc);
                check(link_dst == VECS[i].li, "R2", "link_dst", 64'(link_dst), 64'(VECS[i].li));
            end
        end

        // R8 one-cycle pulse, result held while idle
        drive(VECS[1]);
        @(posedge clk); #1;
        check(out_valid == 0, "R8", "pulse width", out_valid, 0);
        check(next_pc == 64'h124, "R8", "hold next_pc", next_pc, 64'h124);
        opnd_b = 64'h9999; op = 5'b00001; fall_pc = 64'h1;
        @(posedge clk); #1;
        check(next_pc == 64'h124, "R8", "ignore idle inputs", next_pc, 64'h124);

        // R8 back-to-back requests
        op = 5'b01001; opnd_a = 1; opnd_b = 1; offset = 64'h2; fall_pc = 64'h10; in_valid = 1;
        @(posedge clk); #1;
        check(out_valid && next_pc == 64'h12, "R8", "b2b first", next_pc, 64'h12);
        opnd_b = 2;
        @(posedge clk); #1;
        in_valid = 0;
        check(out_valid && next_pc == 64'h10 && !taken, "R5", "b2b second", next_pc, 64'h10);

        // R9 reset in mid-stream
        drive(VECS[0]);
        rst_n = 0;
        @(posedge clk); #1;
        check(!out_valid && !taken && !link_we && next_pc == 0, "R9", "mid reset",
              {out_valid, taken, link_we}, 0);
        rst_n = 1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule